// File: doc/BRIEF.md
# Pipelined Floating-Point Product Normalizer

This block sits behind the significand multiplier of a floating-point multiply unit. It takes the raw double-width product of two significands, which include their hidden bits, together with the provisional exponent. It returns the fraction bits of the normalized result and the exponent corrected for the shift that was applied. The sign path, exponent addition, rounding and special-value handling are outside the block.

The leading one is found by cutting the product into 4-bit groups. Each group works out, at the same time as the others, the left-shift amount that would apply if the leading one sat inside it, and whether all four of its bits are zero. The zero flags then pick one candidate through a tree of three multiplexer levels. The two top product bits choose the action. When the top bit is set, the product is shifted right by one. When the top bit is clear and the next bit is set, the product passes through unshifted. In every other case it is shifted left by the detected amount. The work is spread over three registered stages, and the block accepts a new operand on every clock.

Top module: `fpn_normalize`

## Requirements
- R1: `out_valid` rises exactly three rising clock edges after the edge that samples `in_valid` high. A new operand may be presented on every cycle, and results come out in input order with no gaps and no extra results.
- R2: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_frac`, `out_exp` and `out_zero` are all 0.
- R3: When product bit 47 is 1, `out_frac` equals product bits 46 down to 24 and `out_exp` equals the input exponent plus 1.
- R4: When product bits 47:46 are `01`, `out_frac` equals product bits 45 down to 23 and `out_exp` equals the input exponent unchanged.
- R5: When the highest set product bit is at position k, with k at most 45, the product is shifted left by 46-k. `out_frac` is then bits 45 down to 23 of the shifted product, and `out_exp` is the input exponent minus (46-k).
- R6: An all-zero product gives `out_zero`=1, `out_frac`=0 and `out_exp`=0. Any non-zero product gives `out_zero`=0.
- R7: `out_exp` is a 10-bit two's-complement value computed modulo 2^10. For example, 511+1 gives -512, and -500-46 gives 478.
- R8: Product bits below the chosen fraction field are dropped without rounding, even when all of them are 1.
- R9: R5 holds for a leading one in every 4-bit group, including at bit 0, which needs the largest shift of 46.
- R10: In cycles where `out_valid` is 0, `out_frac`, `out_exp` and `out_zero` keep their previous values, whatever is driven on the inputs with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operand is valid this cycle |
| in_prod | input | 48 | Raw significand product |
| in_exp | input | 10 | Provisional exponent, two's complement |
| out_valid | output | 1 | Result valid this cycle |
| out_frac | output | 23 | Fraction bits below the normalized leading one, truncated |
| out_exp | output | 10 | Corrected exponent, two's complement |
| out_zero | output | 1 | Product was zero |

## Verification
A wrong zero flag or candidate in one group shows up as a fraction shifted by the wrong number of places. It also gives an exponent off by the same amount, on the third edge after that operand enters. So a leading one is walked through every bit position, each with its own expected shift. A valid bit lost or duplicated between stages shows at the ports as a result on the wrong cycle or a missing result. The scoreboard compares the arrival cycle of every result against its due cycle. A stage register that loads while idle would change held outputs, so garbage is driven with `in_valid` low and the held outputs are watched.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  // Width of every shift-amount field; covers products up to 255 bits.
  localparam int CAND_W = 8;

  // Per-group leading-one candidate.
  typedef struct packed {
    logic              zero;
    logic [CAND_W-1:0] amt;
  } lz_cand_t;

  // Pick the more significant candidate unless it is all zero.
  function automatic lz_cand_t cand_merge(input lz_cand_t hi, input lz_cand_t lo);
    lz_cand_t r;
    r.zero = hi.zero & lo.zero;
    r.amt  = hi.zero ? lo.amt : hi.amt;
    return r;
  endfunction

endpackage

// File: rtl/fpn_group_lzd.sv
module fpn_group_lzd
  import fpn_pkg::*;
#(
  parameter int GRP_W   = 4,
  parameter int GRP_IDX = 0   // 0 = most significant group
) (
  input  logic [GRP_W-1:0] grp_bits,
  output lz_cand_t         cand
);

  localparam int BASE = GRP_IDX * GRP_W;

  always_comb begin
    cand.zero = 1'b1;
    cand.amt  = CAND_W'(BASE + GRP_W);
    // Ascending scan: the highest set bit is written last and wins.
    for (int i = 0; i < GRP_W; i++) begin
      if (grp_bits[i]) begin
        cand.zero = 1'b0;
        cand.amt  = CAND_W'(BASE + GRP_W - 1 - i);
      end
    end
  end

endmodule

// File: rtl/fpn_lz_tree.sv
module fpn_lz_tree
  import fpn_pkg::*;
#(
  parameter int NG = 12
) (
  input  lz_cand_t [NG-1:0]  cand_i,   // index 0 = most significant group
  output logic [CAND_W-1:0]  lz_amt,
  output logic               all_zero
);

  localparam int N1 = (NG + 1) / 2;
  localparam int N2 = (N1 + 1) / 2;

  lz_cand_t [N1-1:0] lvl1;
  lz_cand_t [N2-1:0] lvl2;
  lz_cand_t          fin;

  // Level 1: pairs of groups.
  for (genvar j = 0; j < N1; j++) begin : g_lvl1
    if (2*j + 1 < NG) begin : g_pair
      assign lvl1[j] = cand_merge(cand_i[2*j], cand_i[2*j+1]);
    end else begin : g_pass
      assign lvl1[j] = cand_i[2*j];
    end
  end

  // Level 2: pairs of level-1 results.
  for (genvar j = 0; j < N2; j++) begin : g_lvl2
    if (2*j + 1 < N1) begin : g_pair
      assign lvl2[j] = cand_merge(lvl1[2*j], lvl1[2*j+1]);
    end else begin : g_pass
      assign lvl2[j] = lvl1[2*j];
    end
  end

  // Level 3: priority over the remaining entries.
  always_comb begin
    fin = lvl2[N2-1];
    for (int j = N2 - 2; j >= 0; j--) begin
      fin = cand_merge(lvl2[j], fin);
    end
  end

  assign lz_amt   = fin.amt;
  assign all_zero = fin.zero;

endmodule

// File: rtl/fpn_norm_shift.sv
module fpn_norm_shift
  import fpn_pkg::*;
#(
  parameter int PROD_W = 48,
  parameter int EXP_W  = 10,
  parameter int FRAC_W = 23
) (
  input  logic [PROD_W-1:0]        prod,
  input  logic signed [EXP_W-1:0]  exp_in,
  input  logic [CAND_W-1:0]        lz,        // leading zeros above the leading one
  input  logic                     all_zero,
  output logic [FRAC_W-1:0]        frac,
  output logic signed [EXP_W-1:0]  exp_out
);

  localparam int RSH_POS = PROD_W - 1 - FRAC_W;  // fraction offset, right-shift case
  localparam int LSH_POS = PROD_W - 2 - FRAC_W;  // fraction offset, left-shift case

  logic [CAND_W-1:0] sh;

  always_comb begin
    sh      = '0;
    frac    = '0;
    exp_out = '0;
    if (all_zero) begin
      frac    = '0;
      exp_out = '0;
    end else if (lz == '0) begin
      // Top bit set: move right by one place.
      frac    = FRAC_W'(prod >> RSH_POS);
      exp_out = exp_in + EXP_W'(1);
    end else begin
      // Leading one at or below the second bit: move left by lz-1 places.
      sh      = lz - CAND_W'(1);
      frac    = FRAC_W'((prod << sh) >> LSH_POS);
      exp_out = exp_in - EXP_W'(sh);
    end
  end

endmodule

// File: rtl/fpn_normalize.sv
module fpn_normalize
  import fpn_pkg::*;
#(
  parameter int PROD_W = 48,
  parameter int GRP_W  = 4,
  parameter int EXP_W  = 10,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PROD_W-1:0]        in_prod,
  input  logic signed [EXP_W-1:0]  in_exp,
  output logic                     out_valid,
  output logic [FRAC_W-1:0]        out_frac,
  output logic signed [EXP_W-1:0]  out_exp,
  output logic                     out_zero
);

  localparam int NG = PROD_W / GRP_W;

  // ---------------- Stage A: per-group detection ----------------
  lz_cand_t [NG-1:0] cand_a;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    fpn_group_lzd #(
      .GRP_W  (GRP_W),
      .GRP_IDX(g)
    ) u_grp (
      .grp_bits(in_prod[PROD_W-1-g*GRP_W -: GRP_W]),
      .cand    (cand_a[g])
    );
  end

  logic                     s1_valid;
  logic [PROD_W-1:0]        s1_prod;
  logic signed [EXP_W-1:0]  s1_exp;
  lz_cand_t [NG-1:0]        s1_cand;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    if (in_valid) begin
      s1_prod <= in_prod;
      s1_exp  <= in_exp;
      s1_cand <= cand_a;
    end
  end

  // ---------------- Stage B: three-level selection ----------------
  logic [CAND_W-1:0] lz_b;
  logic              zero_b;

  fpn_lz_tree #(
    .NG(NG)
  ) u_tree (
    .cand_i  (s1_cand),
    .lz_amt  (lz_b),
    .all_zero(zero_b)
  );

  logic                     s2_valid;
  logic [PROD_W-1:0]        s2_prod;
  logic signed [EXP_W-1:0]  s2_exp;
  logic [CAND_W-1:0]        s2_lz;
  logic                     s2_zero;

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    if (s1_valid) begin
      s2_prod <= s1_prod;
      s2_exp  <= s1_exp;
      s2_lz   <= lz_b;
      s2_zero <= zero_b;
    end
  end

  // ---------------- Stage C: shift and exponent fix ----------------
  logic [FRAC_W-1:0]        frac_c;
  logic signed [EXP_W-1:0]  exp_c;

  fpn_norm_shift #(
    .PROD_W(PROD_W),
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
  ) u_shift (
    .prod    (s2_prod),
    .exp_in  (s2_exp),
    .lz      (s2_lz),
    .all_zero(s2_zero),
    .frac    (frac_c),
    .exp_out (exp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_frac  <= '0;
      out_exp   <= '0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_frac <= frac_c;
        out_exp  <= exp_c;
        out_zero <= s2_zero;
      end
    end
  end

endmodule

// File: rtl/fpn_normalize_chk.sv
module fpn_normalize_chk #(
  parameter int PROD_W = 48,
  parameter int EXP_W  = 10,
  parameter int FRAC_W = 23
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [PROD_W-1:0]        in_prod,
  input logic signed [EXP_W-1:0]  in_exp,
  input logic                     out_valid,
  input logic [FRAC_W-1:0]        out_frac,
  input logic signed [EXP_W-1:0]  out_exp,
  input logic                     out_zero
);

  // Input history aligned with the registered outputs.
  logic              h1_v, h2_v, h3_v;
  logic [PROD_W-1:0] h1_p, h2_p, h3_p;
  logic [EXP_W-1:0]  h1_e, h2_e, h3_e;
  logic [EXP_W-1:0]  h3_e_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      h1_v <= 1'b0; h2_v <= 1'b0; h3_v <= 1'b0;
      h1_p <= '0;   h2_p <= '0;   h3_p <= '0;
      h1_e <= '0;   h2_e <= '0;   h3_e <= '0;
    end else begin
      h1_v <= in_valid; h2_v <= h1_v; h3_v <= h2_v;
      h1_p <= in_prod;  h2_p <= h1_p; h3_p <= h2_p;
      h1_e <= in_exp;   h2_e <= h1_e; h3_e <= h2_e;
    end
  end

  assign h3_e_inc = h3_e + EXP_W'(1);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == h3_v); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_frac == '0 && out_exp == '0 && !out_zero)); // R2

  AST_RIGHT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && h3_p[PROD_W-1]) |->
      (out_exp == h3_e_inc && out_frac == h3_p[PROD_W-2 -: FRAC_W])); // R3

  AST_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && h3_p[PROD_W-1 -: 2] == 2'b01) |->
      (out_frac == h3_p[PROD_W-3 -: FRAC_W] && out_exp == h3_e)); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zero == (h3_p == '0))); // R6

  AST_ZERO_VALUES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zero) |-> (out_frac == '0 && out_exp == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_frac) && $stable(out_exp) && $stable(out_zero))); // R10

endmodule

bind fpn_normalize fpn_normalize_chk #(
  .PROD_W(PROD_W),
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_prod  (in_prod),
  .in_exp   (in_exp),
  .out_valid(out_valid),
  .out_frac (out_frac),
  .out_exp  (out_exp),
  .out_zero (out_zero)
);

// File: tb/test_fpn_normalize.sv
module test_fpn_normalize;

  localparam int PW = 48;
  localparam int EW = 10;
  localparam int FW = 23;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  in_valid = 1'b0;
  logic [PW-1:0]         in_prod = '0;
  logic signed [EW-1:0]  in_exp = '0;
  logic                  out_valid;
  logic [FW-1:0]         out_frac;
  logic signed [EW-1:0]  out_exp;
  logic                  out_zero;

  fpn_normalize i_fpn_normalize (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_prod  (in_prod),
    .in_exp   (in_exp),
    .out_valid(out_valid),
    .out_frac (out_frac),
    .out_exp  (out_exp),
    .out_zero (out_zero)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [FW-1:0]        frac;
    logic signed [EW-1:0] exp;
    logic                 zero;
    int                   due;
    string                tag;
  } item_t;

  item_t         sb[$];
  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 1'b0;
  logic [PW-1:0] lfsr     = 48'h9E37_79B9_7F4A;

  function automatic logic [PW-1:0] next_rand();
    lfsr = {lfsr[PW-2:0], lfsr[47] ^ lfsr[46] ^ lfsr[20] ^ lfsr[19]};
    return lfsr;
  endfunction

  // Expected result, from the requirements.
  function automatic void model(input logic [PW-1:0] p, input logic signed [EW-1:0] e,
                                output logic [FW-1:0] f, output logic signed [EW-1:0] eo,
                                output logic z);
    int k;
    logic [PW-1:0] sp;
    z = 1'b0; f = '0; eo = '0;
    if (p == '0) begin
      z = 1'b1;
    end else if (p[47]) begin
      f  = p[46:24];
      eo = e + 10'sd1;
    end else begin
      k = 0;
      for (int i = 0; i < 47; i++) if (p[i]) k = i;
      sp = p << (46 - k);
      f  = sp[45:23];
      eo = e - 10'(46 - k);
    end
  endfunction

  task automatic send(input logic [PW-1:0] p, input logic signed [EW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_prod  = p;
    in_exp   = e;
    model(p, e, it.frac, it.exp, it.zero);
    it.due = cyc + 3;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n, input bit garbage);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (garbage) begin
        in_prod = next_rand();
        in_exp  = 10'(in_prod[9:0]);
      end
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Scoreboard monitor, sampling 2 ns after the rising edge.
  logic [FW-1:0]        pf;
  logic signed [EW-1:0] pe;
  logic                 pz;

  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R1: result with no pending operand at cycle %0d (actual valid=1 expected 0)", cyc);
        end else begin
          item_t it;
          it = sb.pop_front();
          n_checks++;
          if (it.due != cyc) begin
            n_fail++;
            $display("FAIL R1 latency [%s]: actual cycle %0d expected %0d", it.tag, cyc, it.due);
          end
          n_checks++;
          if (out_frac !== it.frac || out_exp !== it.exp || out_zero !== it.zero) begin
            n_fail++;
            $display("FAIL %s: actual frac=%h exp=%0d zero=%b expected frac=%h exp=%0d zero=%b",
                     it.tag, out_frac, out_exp, out_zero, it.frac, it.exp, it.zero);
          end
        end
      end else begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
          n_checks++; n_fail++;
          $display("FAIL R1 [%s]: missing result at cycle %0d (actual valid=0 expected 1)", sb[0].tag, cyc);
          void'(sb.pop_front());
        end
        n_checks++;
        if (out_frac !== pf || out_exp !== pe || out_zero !== pz) begin
          n_fail++;
          $display("FAIL R10 hold: actual frac=%h exp=%0d zero=%b expected frac=%h exp=%0d zero=%b",
                   out_frac, out_exp, out_zero, pf, pe, pz);
        end
      end
    end
    pf = out_frac; pe = out_exp; pz = out_zero;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R1: watchdog expired (actual running, expected finished)");
    done = 1'b1;
    summary();
  end

  initial begin
    // R2: reset state, during and just after reset
    repeat (4) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_frac !== '0 || out_exp !== '0 || out_zero !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 in reset: actual v=%b f=%h e=%0d z=%b expected all 0",
               out_valid, out_frac, out_exp, out_zero);
    end
    rst = 1'b0;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_frac !== '0 || out_exp !== '0 || out_zero !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 after reset: actual v=%b f=%h e=%0d z=%b expected all 0",
               out_valid, out_frac, out_exp, out_zero);
    end

    // R3: top bit set
    send(48'h8000_0000_0001, 10'sd10, "R3 top bit");
    send(48'hFFFF_FFFF_FFFF, -10'sd3, "R3 all ones");
    idle(2, 1'b0);

    // R4: leading pattern 01
    send(48'h4000_0000_0000, 10'sd0,   "R4 exact");
    send(48'h5A5A_5A5A_5A5A, -10'sd77, "R4 mixed");
    idle(1, 1'b0);

    // R5 / R9: leading one at every position below bit 46
    for (int k = 45; k >= 0; k--) begin
      logic [PW-1:0] low, p;
      low = (k > 0) ? (next_rand() & ((48'h1 << k) - 48'h1)) : '0;
      p   = (48'h1 << k) | low;
      send(p, 10'sd100, (k % 4 == 0) ? "R9 group walk" : "R5 left shift");
    end

    // R6: zero product
    send(48'h0, 10'sd123, "R6 zero");
    send(48'h0000_0000_0001, 10'sd5, "R6 nonzero smallest");

    // R7: exponent wrap in both directions
    send(48'h8000_0000_0000, 10'sd511,  "R7 wrap up");
    send(48'h0000_0000_0001, -10'sd500, "R7 wrap down");

    // R8: truncation with all-ones tails
    send(48'h7FFF_FFFF_FFFF, 10'sd1, "R8 truncate no shift");
    send(48'h000F_FFFF_FFFF, 10'sd1, "R8 truncate left");
    send(48'hFFFF_FFFF_FFFF, 10'sd1, "R8 truncate right");

    // R10: idle with garbage on the inputs
    idle(6, 1'b1);

    // R1: back-to-back stream
    for (int i = 0; i < 24; i++) begin
      logic [PW-1:0] p;
      p = next_rand() >> (i % 48);
      send(p, 10'(i * 37), "R1 stream");
    end
    idle(3, 1'b1);
    send(48'h0000_1234_0000, -10'sd2, "R1 after gap");
    idle(8, 1'b1);

    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: actual %0d results outstanding, expected 0", sb.size());
    end
    done = 1'b1;
    summary();
  end

endmodule